// File: doc/BRIEF.md
# Write Command and Data Pairing Stage

This stage sits in front of a DRAM controller's burst engine. Software-facing logic sends write data words, each with a per-byte mask and an end-of-burst flag, into a write-data queue. It sends write commands, each carrying an address, on a separate channel with its own handshake. The stage binds each command to the next complete burst of buffered data, taking data in arrival order, and presents the combined address, data and mask downstream on a valid/ready channel.

Data may arrive before its command. It may also arrive after it, and a gap of two cycles or more is normal. A burst is released only when both halves are present. A static mode input selects the clock ratio. In half-rate mode a burst is two user words. In quarter-rate mode a burst is one user word. The end-of-burst flag is checked against the word position implied by the mode. A misplaced flag raises a sticky error, and framing still follows the word count.

Top module: `wrPair`

## Requirements
- R1: A data word is stored only in a cycle with `wdfValid` and `wdfReady` both high. `wdfReady` is low while the queue holds 2*FIFO_BURSTS words. A word held on the inputs while `wdfReady` is low is never stored.
- R2: A command is stored only in a cycle with `cmdValid` and `cmdReady` both high. `cmdReady` is low while CMD_DEPTH commands are queued.
- R3: Data pushed before any command is buffered. It is bound to commands in arrival order, the oldest data to the oldest command.
- R4: `outValid` is high only when a command and all of its burst's words are stored. Data arriving two or more cycles after its command still pairs with that command.
- R5: With `ratioMode`=0, a burst is two words. `outData` is {second word, first word} and `outMask` is {second mask, first mask}. A mask bit of 1 means that byte is not written.
- R6: With `ratioMode`=1, a burst is one word. `outData` carries it in the low half and zero in the high half. The high half of `outMask` is all ones.
- R7: The end flag is expected on the second word in mode 0 and on every word in mode 1. If it is missing where expected, or set where it is not expected, `protoErr` goes high and stays high until reset. The burst is still formed by word count.
- R8: Bursts leave in command-acceptance order. While `outValid` is high and `outReady` is low, `outValid`, `outAddr`, `outData` and `outMask` hold.
- R9: After reset, `wdfReady`=1, `cmdReady`=1, `outValid`=0 and `protoErr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ratioMode | input | 1 | 0: two words per burst, 1: one word per burst |
| wdfValid | input | 1 | Data word valid |
| wdfEnd | input | 1 | End-of-burst flag for this word |
| wdfData | input | DATA_W | Data word |
| wdfMask | input | DATA_W/8 | Byte mask, 1 = byte not written |
| wdfReady | output | 1 | Data queue can accept a word |
| cmdValid | input | 1 | Write command valid |
| cmdAddr | input | ADDR_W | Write address |
| cmdReady | output | 1 | Command queue can accept |
| outValid | output | 1 | Paired burst available |
| outReady | input | 1 | Downstream takes the burst |
| outAddr | output | ADDR_W | Burst address |
| outData | output | 2*DATA_W | Burst data, first word low |
| outMask | output | DATA_W/4 | Burst byte mask, first word low |
| protoErr | output | 1 | Sticky misplaced end-flag error |

## Verification
The bench builds the block with 16-bit words, 8-bit addresses, four bursts of data buffering (eight words) and a two-entry command queue. The small command queue makes the full condition reachable after two commands. It lets the bench check command back-pressure and in-order binding of pre-pushed data. The eight-word data queue is filled in quarter-rate mode to show that a word held against a low ready is dropped. The bench also changes the clock-ratio mode between idle periods, so both output layouts and both end-flag rules are covered.

// File: rtl/wrPairPkg.sv
package wrPairPkg;
  typedef struct packed {
    logic pushData;
    logic pushCmd;
    logic popBurst;
    logic popTwo;
  } wrStrobe_t;
endpackage

// File: rtl/wrPairCtrl.sv
module wrPairCtrl
  import wrPairPkg::*;
#(
  parameter int DATA_DEPTH = 8,
  parameter int CMD_DEPTH  = 4,
  localparam int DCW = $clog2(DATA_DEPTH + 1),
  localparam int CCW = $clog2(CMD_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           ratioMode,
  input  logic           wdfValid,
  input  logic           wdfEnd,
  input  logic           cmdValid,
  input  logic           outReady,
  output logic           wdfReady,
  output logic           cmdReady,
  output logic           outValid,
  output logic           protoErr,
  output wrStrobe_t      strobe,
  output logic [DCW-1:0] dataCount,
  output logic [CCW-1:0] cmdCount
);
  logic [DCW-1:0] need;
  logic           wordPos;
  logic           endBad;

  assign need     = ratioMode ? DCW'(1) : DCW'(2);
  assign wdfReady = (dataCount != DCW'(DATA_DEPTH));
  assign cmdReady = (cmdCount != CCW'(CMD_DEPTH));
  assign outValid = (cmdCount != '0) && (dataCount >= need);

  always_comb begin
    strobe.pushData = wdfValid && wdfReady;
    strobe.pushCmd  = cmdValid && cmdReady;
    strobe.popBurst = outValid && outReady;
    strobe.popTwo   = !ratioMode;
  end

  // expected flag: last word of the burst carries it
  assign endBad = (ratioMode || wordPos) ? !wdfEnd : wdfEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataCount <= '0;
      cmdCount  <= '0;
      wordPos   <= 1'b0;
      protoErr  <= 1'b0;
    end else begin
      dataCount <= dataCount + (strobe.pushData ? DCW'(1) : DCW'(0))
                             - (strobe.popBurst ? need : DCW'(0));
      cmdCount  <= cmdCount + (strobe.pushCmd ? CCW'(1) : CCW'(0))
                            - (strobe.popBurst ? CCW'(1) : CCW'(0));
      if (strobe.pushData) begin
        wordPos <= ratioMode ? 1'b0 : !wordPos;
        if (endBad) protoErr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wrPairData.sv
module wrPairData
  import wrPairPkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16,
  parameter int DATA_DEPTH = 8,
  parameter int CMD_DEPTH  = 4,
  localparam int MASK_W = DATA_W / 8,
  localparam int DPW    = (DATA_DEPTH > 1) ? $clog2(DATA_DEPTH) : 1,
  localparam int CPW    = (CMD_DEPTH > 1) ? $clog2(CMD_DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           strobe,
  input  logic [DATA_W-1:0]   wdfData,
  input  logic [MASK_W-1:0]   wdfMask,
  input  logic [ADDR_W-1:0]   cmdAddr,
  output logic [ADDR_W-1:0]   outAddr,
  output logic [2*DATA_W-1:0] outData,
  output logic [2*MASK_W-1:0] outMask
);
  logic [DATA_W-1:0] dataMem [DATA_DEPTH];
  logic [MASK_W-1:0] maskMem [DATA_DEPTH];
  logic [ADDR_W-1:0] addrMem [CMD_DEPTH];
  logic [DPW-1:0] dWr, dRd0, dRd1;
  logic [CPW-1:0] cWr, cRd;

  function automatic logic [DPW-1:0] dInc(input logic [DPW-1:0] p);
    return (p == DPW'(DATA_DEPTH - 1)) ? '0 : p + DPW'(1);
  endfunction

  function automatic logic [CPW-1:0] cInc(input logic [CPW-1:0] p);
    return (p == CPW'(CMD_DEPTH - 1)) ? '0 : p + CPW'(1);
  endfunction

  assign dRd1 = dInc(dRd0);

  always_ff @(posedge clk) begin
    if (strobe.pushData) begin
      dataMem[dWr] <= wdfData;
      maskMem[dWr] <= wdfMask;
    end
    if (strobe.pushCmd) addrMem[cWr] <= cmdAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dWr  <= '0;
      dRd0 <= '0;
      cWr  <= '0;
      cRd  <= '0;
    end else begin
      if (strobe.pushData) dWr <= dInc(dWr);
      if (strobe.pushCmd)  cWr <= cInc(cWr);
      if (strobe.popBurst) begin
        dRd0 <= strobe.popTwo ? dInc(dRd1) : dRd1;
        cRd  <= cInc(cRd);
      end
    end
  end

  assign outAddr = addrMem[cRd];

  always_comb begin
    if (strobe.popTwo) begin
      outData = {dataMem[dRd1], dataMem[dRd0]};
      outMask = {maskMem[dRd1], maskMem[dRd0]};
    end else begin
      outData = {{DATA_W{1'b0}}, dataMem[dRd0]};
      outMask = {{MASK_W{1'b1}}, maskMem[dRd0]};
    end
  end
endmodule

// File: rtl/wrPair.sv
module wrPair
  import wrPairPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 16,
  parameter int FIFO_BURSTS = 4,
  parameter int CMD_DEPTH   = 4,
  localparam int MASK_W     = DATA_W / 8,
  localparam int DATA_DEPTH = 2 * FIFO_BURSTS,
  localparam int DCW        = $clog2(DATA_DEPTH + 1),
  localparam int CCW        = $clog2(CMD_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ratioMode,
  input  logic                wdfValid,
  input  logic                wdfEnd,
  input  logic [DATA_W-1:0]   wdfData,
  input  logic [MASK_W-1:0]   wdfMask,
  output logic                wdfReady,
  input  logic                cmdValid,
  input  logic [ADDR_W-1:0]   cmdAddr,
  output logic                cmdReady,
  output logic                outValid,
  input  logic                outReady,
  output logic [ADDR_W-1:0]   outAddr,
  output logic [2*DATA_W-1:0] outData,
  output logic [2*MASK_W-1:0] outMask,
  output logic                protoErr
);
  wrStrobe_t      strobe;
  logic [DCW-1:0] dataCount;
  logic [CCW-1:0] cmdCount;

  wrPairCtrl #(.DATA_DEPTH(DATA_DEPTH), .CMD_DEPTH(CMD_DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .ratioMode(ratioMode), .wdfValid(wdfValid),
    .wdfEnd(wdfEnd), .cmdValid(cmdValid), .outReady(outReady),
    .wdfReady(wdfReady), .cmdReady(cmdReady), .outValid(outValid),
    .protoErr(protoErr), .strobe(strobe), .dataCount(dataCount),
    .cmdCount(cmdCount)
  );

  wrPairData #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DATA_DEPTH(DATA_DEPTH),
               .CMD_DEPTH(CMD_DEPTH)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdfData(wdfData),
    .wdfMask(wdfMask), .cmdAddr(cmdAddr), .outAddr(outAddr),
    .outData(outData), .outMask(outMask)
  );
endmodule

// File: rtl/wrPairChk.sv
module wrPairChk #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 16,
  parameter int FIFO_BURSTS = 4,
  parameter int CMD_DEPTH   = 4,
  localparam int MASK_W     = DATA_W / 8,
  localparam int DATA_DEPTH = 2 * FIFO_BURSTS,
  localparam int DCW        = $clog2(DATA_DEPTH + 1),
  localparam int CCW        = $clog2(CMD_DEPTH + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic                wdfValid,
  input logic                wdfReady,
  input logic                cmdValid,
  input logic                cmdReady,
  input logic                outValid,
  input logic                outReady,
  input logic [ADDR_W-1:0]   outAddr,
  input logic [2*DATA_W-1:0] outData,
  input logic [2*MASK_W-1:0] outMask,
  input logic                protoErr,
  input logic [DCW-1:0]      dataCount,
  input logic [CCW-1:0]      cmdCount
);
  a_r1_no_capture_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (wdfValid && !wdfReady && !(outValid && outReady)) |=> dataCount == $past(dataCount));

  a_r1_data_bound: assert property (@(posedge clk) disable iff (!rstN)
    dataCount <= DCW'(DATA_DEPTH));

  a_r2_no_cmd_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady && !(outValid && outReady)) |=> cmdCount == $past(cmdCount));

  a_r4_needs_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCount == '0) |-> !outValid);

  a_r8_stall_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outAddr) && $stable(outData)
                                && $stable(outMask));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);
endmodule

bind wrPair wrPairChk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIFO_BURSTS(FIFO_BURSTS),
                        .CMD_DEPTH(CMD_DEPTH)) i_chk (
  .clk(clk), .rstN(rstN), .wdfValid(wdfValid), .wdfReady(wdfReady),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .outValid(outValid),
  .outReady(outReady), .outAddr(outAddr), .outData(outData), .outMask(outMask),
  .protoErr(protoErr), .dataCount(dataCount), .cmdCount(cmdCount)
);

// File: tb/test_wrPair.sv
`timescale 1ns/1ps
module test_wrPair;
  localparam int DW = 16, AW = 8, FB = 4, CD = 2, MW = DW / 8;
  localparam time CYC = 4ns;

  logic clk = 1'b0, rstN = 1'b0, ratioMode = 1'b0;
  logic wdfValid = 1'b0, wdfEnd = 1'b0, cmdValid = 1'b0, outReady = 1'b0;
  logic [DW-1:0] wdfData = '0;
  logic [MW-1:0] wdfMask = '0;
  logic [AW-1:0] cmdAddr = '0;
  logic wdfReady, cmdReady, outValid, protoErr;
  logic [AW-1:0] outAddr;
  logic [2*DW-1:0] outData;
  logic [2*MW-1:0] outMask;
  int errors = 0, checks = 0;

  always #(CYC/2) clk = ~clk;

  wrPair #(.DATA_W(DW), .ADDR_W(AW), .FIFO_BURSTS(FB), .CMD_DEPTH(CD)) i_wrPair (
    .clk(clk), .rstN(rstN), .ratioMode(ratioMode), .wdfValid(wdfValid),
    .wdfEnd(wdfEnd), .wdfData(wdfData), .wdfMask(wdfMask), .wdfReady(wdfReady),
    .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdReady(cmdReady),
    .outValid(outValid), .outReady(outReady), .outAddr(outAddr),
    .outData(outData), .outMask(outMask), .protoErr(protoErr)
  );

  typedef struct packed {
    logic          mode;
    logic          dataFirst;
    logic [AW-1:0] addr;
    logic [DW-1:0] w0;
    logic [MW-1:0] m0;
    logic [DW-1:0] w1;
    logic [MW-1:0] m1;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 1'b1, 8'h11, 16'hA001, 2'b00, 16'hB002, 2'b10},
    '{1'b0, 1'b0, 8'h22, 16'hC003, 2'b01, 16'hD004, 2'b00},
    '{1'b1, 1'b1, 8'h33, 16'hE005, 2'b10, 16'h0000, 2'b00},
    '{1'b1, 1'b0, 8'h44, 16'hF006, 2'b11, 16'h0000, 2'b00}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pushWord(input logic [DW-1:0] d, input logic [MW-1:0] m, input logic e);
    @(negedge clk);
    wdfValid = 1'b1; wdfData = d; wdfMask = m; wdfEnd = e;
    while (!wdfReady) @(negedge clk);
    @(posedge clk); #1;
    wdfValid = 1'b0;
  endtask

  task automatic pushCmd(input logic [AW-1:0] a);
    @(negedge clk);
    cmdValid = 1'b1; cmdAddr = a;
    while (!cmdReady) @(negedge clk);
    @(posedge clk); #1;
    cmdValid = 1'b0;
  endtask

  task automatic takeBurst(input logic [AW-1:0] a, input logic [2*DW-1:0] d,
                           input logic [2*MW-1:0] m, input string tag);
    int n = 0;
    @(negedge clk);
    while (!outValid && n < 20) begin @(negedge clk); n++; end
    check(outValid, {tag, " valid"}, 64'(outValid), 64'd1);
    check(outAddr == a, {tag, " addr"}, 64'(outAddr), 64'(a));
    check(outData == d, {tag, " data"}, 64'(outData), 64'(d));
    check(outMask == m, {tag, " mask"}, 64'(outMask), 64'(m));
    outReady = 1'b1;
    @(posedge clk); #1;
    outReady = 1'b0;
  endtask

  initial begin
    #(CYC * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(wdfReady == 1'b1, "R9 wdfReady", 64'(wdfReady), 64'd1);
    check(cmdReady == 1'b1, "R9 cmdReady", 64'(cmdReady), 64'd1);
    check(outValid == 1'b0, "R9 outValid", 64'(outValid), 64'd0);
    check(protoErr == 1'b0, "R9 protoErr", 64'(protoErr), 64'd0);

    // vector walk: R3 data first, R4 command first, R5 and R6 layouts
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      logic [2*DW-1:0] ed = v.mode ? {16'h0, v.w0} : {v.w1, v.w0};
      logic [2*MW-1:0] em = v.mode ? {2'b11, v.m0} : {v.m1, v.m0};
      ratioMode = v.mode;
      if (v.dataFirst) begin
        pushWord(v.w0, v.m0, v.mode);
        if (!v.mode) pushWord(v.w1, v.m1, 1'b1);
        repeat (2) @(negedge clk);
        check(!outValid, "R3 data without cmd held", 64'(outValid), 64'd0);
        pushCmd(v.addr);
      end else begin
        pushCmd(v.addr);
        repeat (2) @(negedge clk);
        check(!outValid, "R4 cmd without data held", 64'(outValid), 64'd0);
        pushWord(v.w0, v.m0, v.mode);
        if (!v.mode) begin
          @(negedge clk);
          check(!outValid, "R4 half burst held", 64'(outValid), 64'd0);
          pushWord(v.w1, v.m1, 1'b1);
        end
      end
      takeBurst(v.addr, ed, em, v.mode ? "R6 vector" : "R5 vector");
    end

    // R2 command queue full, then R3 and R8 in-order binding
    ratioMode = 1'b0;
    pushCmd(8'h51);
    pushCmd(8'h52);
    @(negedge clk);
    check(!cmdReady, "R2 cmdReady low when full", 64'(cmdReady), 64'd0);
    pushWord(16'h1111, 2'b00, 1'b0);
    pushWord(16'h2222, 2'b00, 1'b1);
    pushWord(16'h3333, 2'b01, 1'b0);
    pushWord(16'h4444, 2'b00, 1'b1);
    @(negedge clk);
    repeat (3) @(negedge clk);
    check(outValid && outAddr == 8'h51, "R8 stall hold addr", 64'(outAddr), 64'h51);
    check(outData == 32'h2222_1111, "R8 stall hold data", 64'(outData), 64'h22221111);
    takeBurst(8'h51, 32'h2222_1111, 4'b0000, "R8 first");
    takeBurst(8'h52, 32'h4444_3333, 4'b0001, "R8 second");

    // R1 data queue full, a held word is dropped
    ratioMode = 1'b1;
    for (int k = 0; k < 2*FB; k++) pushWord(16'h0100 + 16'(k), 2'b00, 1'b1);
    @(negedge clk);
    check(!wdfReady, "R1 wdfReady low when full", 64'(wdfReady), 64'd0);
    wdfValid = 1'b1; wdfData = 16'hDEAD; wdfMask = 2'b00; wdfEnd = 1'b1;
    repeat (3) @(negedge clk);
    wdfValid = 1'b0;
    for (int k = 0; k < 2*FB; k++) begin
      pushCmd(8'h60 + 8'(k));
      takeBurst(8'h60 + 8'(k), {16'h0, 16'h0100 + 16'(k)}, 4'b1100, "R1 drain");
    end
    pushCmd(8'h70);
    repeat (4) @(negedge clk);
    check(!outValid, "R1 held word not stored", 64'(outValid), 64'd0);
    pushWord(16'h7777, 2'b00, 1'b1);
    takeBurst(8'h70, 32'h0000_7777, 4'b1100, "R1 next word");
    check(!protoErr, "R7 no error on good framing", 64'(protoErr), 64'd0);

    // R7 misplaced end flag
    ratioMode = 1'b0;
    pushWord(16'h8888, 2'b00, 1'b1);
    pushWord(16'h9999, 2'b00, 1'b1);
    @(negedge clk);
    check(protoErr, "R7 error raised", 64'(protoErr), 64'd1);
    pushCmd(8'h80);
    takeBurst(8'h80, 32'h9999_8888, 4'b0000, "R7 forwarded by count");
    pushCmd(8'h81);
    pushWord(16'hAAAA, 2'b00, 1'b0);
    pushWord(16'hBBBB, 2'b00, 1'b1);
    takeBurst(8'h81, 32'hBBBB_AAAA, 4'b0000, "R7 after error");
    check(protoErr, "R7 error sticky", 64'(protoErr), 64'd1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule